// File: doc/BRIEF.md
# Binary FSK Carrier Synthesizer with Transmit Burst Limit

This block turns a serial transmit data line into a frequency-shift-keyed carrier for a mains signalling modem. A 32-bit phase accumulator is clocked from the 11.0592 MHz reference. Each clock it advances by one of two increments that are worked out when the design is built: 133.05 kHz while the data line is 0 and 131.85 kHz while it is 1. The swing is 1200 Hz peak-to-peak about 132.45 kHz. The data line is sampled with no relation to any bit clock, and the tone follows each change of the line at once. The phase carries on unbroken across tone changes. The top phase bits drive a waveform stage, which builds either a parabolic sine or a square wave as a signed sample.

The same block holds the mode controller. A low level on the mode-select line asks for transmit, which turns on the driver output enable and the amplifier bias pair. A burst that runs past a fixed limit (one second by default) is forced back to receive. Transmit is then locked out until the select line has been high for a minimum time of about 2 µs. One test input turns the limit off. A second test input cuts the limit to about 488 µs. While the block is receiving, a second accumulator produces the phase word of a 127.05 kHz local oscillator, which mixes the 132.45 kHz carrier down to 5.4 kHz.

Top module: `fsk_tx_mode`

## Requirements
- R1: While reset is asserted and afterwards with the select line held high, tx_active, drv_oe and pa_bias are 0, pa_bias_n is 1 and carrier is 0.
- R2: rx_tx_sel going low while in receive sets tx_active, drv_oe and pa_bias, and clears pa_bias_n, three clock edges after the first edge that samples the low level (two synchronizer stages plus the mode register).
- R3: While transmitting with tx_data = 0, the carrier repeats at 133.05 kHz: twenty periods of the sign bit take 20·11059200/133050 clocks, within ±3.
- R4: While transmitting with tx_data = 1, the carrier repeats at 131.85 kHz: twenty periods take 20·11059200/131850 clocks, within ±3.
- R5: In sine mode (the default) the phase stays continuous when the tone changes. Two consecutive carrier samples during a burst never differ by more than 2^(OUT_W-1)/8.
- R6: When neither test input is set, a burst lasts exactly TMO_LONG clocks. After that tx_active, drv_oe and pa_bias drop to 0 and pa_bias_n rises to 1, even though rx_tx_sel stays low.
- R7: After a forced drop, transmit comes back only after rx_tx_sel has been high for MIN_HIGH consecutive clocks and then goes low. A high pulse one clock shorter leaves the block in receive.
- R8: With tmo_disable = 1, a burst goes on past TMO_LONG clocks for as long as rx_tx_sel stays low.
- R9: With tmo_short = 1 and tmo_disable = 0, a burst lasts exactly TMO_SHORT clocks.
- R10: rx_tx_sel going high during a burst clears tx_active three edges after the first edge that samples it high.
- R11: In receive, lo_phase advances every clock by floor(127050·2^32/11059200) modulo 2^32. During a burst it holds its value.
- R12: carrier is 0 in every cycle that follows a cycle with tx_active at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 11.0592 MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_tx_sel | input | 1 | Mode request: 0 asks for transmit, 1 for receive |
| tx_data | input | 1 | Asynchronous transmit data, selects the tone |
| tmo_disable | input | 1 | Test: 1 turns off the burst limit |
| tmo_short | input | 1 | Test: 1 selects the short burst limit |
| carrier | output | OUT_W | Signed two's-complement carrier sample, 0 when not transmitting |
| tx_active | output | 1 | 1 while in transmit mode |
| drv_oe | output | 1 | Output enable for the line driver |
| pa_bias | output | 1 | Amplifier bias control, 1 while transmitting |
| pa_bias_n | output | 1 | Complement of pa_bias |
| lo_phase | output | PH_W | Receive local oscillator phase word |

## Verification
The burst-length properties assume that tmo_disable and tmo_short stay fixed for the whole of a burst. The bench therefore changes them only while rx_tx_sel is high and the block has been receiving for several cycles. The property that relates rx_tx_sel to tx_active assumes the select line is a plain level, which the bench holds for whole clock periods. The continuity bound assumes the default sine waveform and the default tone frequencies. The bench keeps both and checks steps only between samples that both fall inside a burst.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  typedef enum logic [1:0] {
    MODE_RX   = 2'd0,
    MODE_TX   = 2'd1,
    MODE_LOCK = 2'd2
  } mode_t;

  // Phase step per reference clock for a tone of hz, on a 2^32 phase circle.
  function automatic logic [31:0] tone_inc(input longint unsigned hz,
                                           input longint unsigned ref_hz);
    longint unsigned num;
    num = hz << 32;
    return 32'(num / ref_hz);
  endfunction

endpackage

// File: rtl/fsk_sync.sv
module fsk_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= RST_VAL;
    else        stg_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/fsk_mode_ctrl.sv
module fsk_mode_ctrl
  import fsk_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int TMO_LONG  = 11059200,
  parameter int TMO_SHORT = 5400,
  parameter int MIN_HIGH  = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_s,
  input  logic tmo_off,
  input  logic tmo_fast,
  output logic tx_en
);

  localparam int HI_W = $clog2(MIN_HIGH + 1);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(TMO_LONG - 1);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(TMO_SHORT - 1);
  localparam logic [HI_W-1:0]  HI_LAST   = HI_W'(MIN_HIGH - 1);

  mode_t            st_q, st_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [CNT_W-1:0] lim_last;
  logic             limit_hit;

  assign lim_last  = tmo_fast ? LIM_SHORT : LIM_LONG;
  assign limit_hit = !tmo_off && (run_q >= lim_last);

  always_comb begin
    st_d  = st_q;
    run_d = '0;
    hi_d  = '0;
    unique case (st_q)
      MODE_RX: begin
        if (!sel_s) st_d = MODE_TX;
      end
      MODE_TX: begin
        if (sel_s) begin
          st_d = MODE_RX;
        end else if (limit_hit) begin
          st_d = MODE_LOCK;
        end else begin
          run_d = (run_q == '1) ? run_q : run_q + 1'b1;
        end
      end
      MODE_LOCK: begin
        if (sel_s) begin
          if (hi_q >= HI_LAST) st_d = MODE_RX;
          else                 hi_d = hi_q + 1'b1;
        end
      end
      default: st_d = MODE_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MODE_RX;
      run_q <= '0;
      hi_q  <= '0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
      hi_q  <= hi_d;
    end
  end

  assign tx_en = (st_q == MODE_TX);

endmodule

// File: rtl/fsk_nco.sv
module fsk_nco #(
  parameter int          PH_W      = 32,
  parameter int          OUT_W     = 12,
  parameter bit          SINE      = 1'b1,
  parameter logic [31:0] INC_SPACE = 32'd0,
  parameter logic [31:0] INC_MARK  = 32'd0,
  parameter logic [31:0] INC_LO    = 32'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             mark,
  output logic [OUT_W-1:0] carrier,
  output logic [PH_W-1:0]  lo_phase
);

  localparam int X_W   = 9;
  localparam int SHIFT = 16 - (OUT_W - 1);
  localparam logic [OUT_W-1:0] FULL = {1'b0, {(OUT_W-1){1'b1}}};

  logic [PH_W-1:0]  ph_q, ph_d, lo_q, lo_d;
  logic [PH_W-1:0]  step;
  logic [OUT_W-1:0] wave, car_d, car_q;
  logic             half;

  assign step = mark ? PH_W'(INC_MARK) : PH_W'(INC_SPACE);
  assign half = ph_q[PH_W-1];

  if (SINE) begin : g_sine
    logic [X_W-1:0]  x;
    logic [X_W-1:0]  xr;
    logic [17:0]     prod;
    logic [OUT_W-1:0] mag;
    assign x    = ph_q[PH_W-2 -: X_W];
    assign xr   = 9'd511 - x;
    assign prod = 18'(x) * 18'(xr);
    assign mag  = OUT_W'(prod >> SHIFT);
    assign wave = half ? (~mag + 1'b1) : mag;
  end else begin : g_square
    assign wave = half ? (~FULL + 1'b1) : FULL;
  end

  always_comb begin
    ph_d  = tx_en ? ph_q + step : ph_q;
    lo_d  = tx_en ? lo_q : lo_q + PH_W'(INC_LO);
    car_d = tx_en ? wave : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      lo_q  <= '0;
      car_q <= '0;
    end else begin
      ph_q  <= ph_d;
      lo_q  <= lo_d;
      car_q <= car_d;
    end
  end

  assign carrier  = car_q;
  assign lo_phase = lo_q;

endmodule

// File: rtl/fsk_tx_mode.sv
module fsk_tx_mode
  import fsk_pkg::*;
#(
  parameter int REF_HZ    = 11059200,
  parameter int SPACE_HZ  = 133050,
  parameter int MARK_HZ   = 131850,
  parameter int LO_HZ     = 127050,
  parameter int PH_W      = 32,
  parameter int OUT_W     = 12,
  parameter bit SINE      = 1'b1,
  parameter int CNT_W     = 24,
  parameter int TMO_LONG  = 11059200,
  parameter int TMO_SHORT = 5400,
  parameter int MIN_HIGH  = 23,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_tx_sel,
  input  logic             tx_data,
  input  logic             tmo_disable,
  input  logic             tmo_short,
  output logic [OUT_W-1:0] carrier,
  output logic             tx_active,
  output logic             drv_oe,
  output logic             pa_bias,
  output logic             pa_bias_n,
  output logic [PH_W-1:0]  lo_phase
);

  localparam logic [31:0] INC_SPACE = tone_inc(longint'(SPACE_HZ), longint'(REF_HZ));
  localparam logic [31:0] INC_MARK  = tone_inc(longint'(MARK_HZ),  longint'(REF_HZ));
  localparam logic [31:0] INC_LO    = tone_inc(longint'(LO_HZ),    longint'(REF_HZ));
  localparam logic [3:0]  IN_IDLE   = 4'b1100;

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic [3:0] raw_in, syn_in;
  logic       tx_en;

  // reset release aligned to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign raw_in = {rx_tx_sel, tx_data, tmo_disable, tmo_short};

  fsk_sync #(.W(4), .STAGES(SYNC_STG), .RST_VAL(IN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (raw_in),
    .q     (syn_in)
  );

  fsk_mode_ctrl #(
    .CNT_W     (CNT_W),
    .TMO_LONG  (TMO_LONG),
    .TMO_SHORT (TMO_SHORT),
    .MIN_HIGH  (MIN_HIGH)
  ) u_mode (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sel_s    (syn_in[3]),
    .tmo_off  (syn_in[1]),
    .tmo_fast (syn_in[0]),
    .tx_en    (tx_en)
  );

  fsk_nco #(
    .PH_W      (PH_W),
    .OUT_W     (OUT_W),
    .SINE      (SINE),
    .INC_SPACE (INC_SPACE),
    .INC_MARK  (INC_MARK),
    .INC_LO    (INC_LO)
  ) u_nco (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tx_en    (tx_en),
    .mark     (syn_in[2]),
    .carrier  (carrier),
    .lo_phase (lo_phase)
  );

  assign tx_active = tx_en;
  assign drv_oe    = tx_en;
  assign pa_bias   = tx_en;
  assign pa_bias_n = ~tx_en;

endmodule

// File: rtl/fsk_tx_mode_chk.sv
module fsk_tx_mode_chk #(
  parameter int PH_W      = 32,
  parameter int OUT_W     = 12,
  parameter int TMO_LONG  = 11059200,
  parameter int TMO_SHORT = 5400
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_tx_sel,
  input logic             tmo_disable,
  input logic             tmo_short,
  input logic [OUT_W-1:0] carrier,
  input logic             tx_active,
  input logic             drv_oe,
  input logic             pa_bias,
  input logic             pa_bias_n,
  input logic [PH_W-1:0]  lo_phase
);

  logic [31:0] burst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         burst_q <= '0;
    else if (tx_active) burst_q <= burst_q + 1'b1;
    else                burst_q <= '0;
  end

  assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> (!drv_oe && !pa_bias && pa_bias_n));

  assert_burst_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !tmo_disable && !tmo_short) |-> (burst_q < 32'(TMO_LONG)));

  assert_burst_limit_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !tmo_disable && tmo_short) |-> (burst_q < 32'(TMO_SHORT)));

  assert_rx_after_sel_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_tx_sel, 3) |-> !tx_active);

  assert_lo_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> $stable(lo_phase));

  assert_quiet_carrier_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_active) |-> (carrier == '0));

endmodule

bind fsk_tx_mode fsk_tx_mode_chk #(
  .PH_W      (PH_W),
  .OUT_W     (OUT_W),
  .TMO_LONG  (TMO_LONG),
  .TMO_SHORT (TMO_SHORT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_tx_sel   (rx_tx_sel),
  .tmo_disable (tmo_disable),
  .tmo_short   (tmo_short),
  .carrier     (carrier),
  .tx_active   (tx_active),
  .drv_oe      (drv_oe),
  .pa_bias     (pa_bias),
  .pa_bias_n   (pa_bias_n),
  .lo_phase    (lo_phase)
);

// File: tb/tb_fsk_tx_mode.sv
`timescale 1ns/1ps
module tb_fsk_tx_mode;

  localparam int CLK_PERIOD = 90;
  localparam int REF_HZ     = 11059200;
  localparam int SPACE_HZ   = 133050;
  localparam int MARK_HZ    = 131850;
  localparam int LO_HZ      = 127050;
  localparam int OUT_W      = 12;
  localparam int PH_W       = 32;
  localparam int T_LONG     = 3000;
  localparam int T_SHORT    = 400;
  localparam int MIN_HI     = 23;
  localparam int NPER       = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             rx_tx_sel, tx_data, tmo_disable, tmo_short;
  logic [OUT_W-1:0] carrier;
  logic             tx_active, drv_oe, pa_bias, pa_bias_n;
  logic [PH_W-1:0]  lo_phase;

  int  cyc = 0;
  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  bit  step_on = 1'b0;
  int  max_step = 0;
  logic signed [OUT_W-1:0] prev_car = '0;

  typedef struct {
    int    at;
    bit    tx;
    string req;
  } exp_t;
  exp_t sbq[$];

  fsk_tx_mode #(
    .OUT_W     (OUT_W),
    .TMO_LONG  (T_LONG),
    .TMO_SHORT (T_SHORT),
    .MIN_HIGH  (MIN_HI)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_tx_sel   (rx_tx_sel),
    .tx_data     (tx_data),
    .tmo_disable (tmo_disable),
    .tmo_short   (tmo_short),
    .carrier     (carrier),
    .tx_active   (tx_active),
    .drv_oe      (drv_oe),
    .pa_bias     (pa_bias),
    .pa_bias_n   (pa_bias_n),
    .lo_phase    (lo_phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver side of the scoreboard: expected mode state at cycle now+delta
  task automatic push_exp(input int delta, input bit tx, input string req);
    exp_t e;
    e.at = cyc + delta;
    e.tx = tx;
    e.req = req;
    sbq.push_back(e);
  endtask

  // monitor side: pops and compares at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      if (e.at < cyc) check(1'b0, e.req, cyc, e.at);
      else check({tx_active, drv_oe, pa_bias, pa_bias_n} == {e.tx, e.tx, e.tx, ~e.tx},
                 e.req, {tx_active, drv_oe, pa_bias, pa_bias_n}, {e.tx, e.tx, e.tx, ~e.tx});
    end
  end

  // sample-to-sample step tracking for the continuity check
  always @(negedge clk) begin
    int d;
    d = int'($signed(carrier)) - int'(prev_car);
    if (d < 0) d = -d;
    if (step_on && d > max_step) max_step = d;
    prev_car = $signed(carrier);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain;
    while (sbq.size() > 0) @(negedge clk);
  endtask

  function automatic longint unsigned inc_of(input longint unsigned hz);
    return (hz << 32) / longint'(REF_HZ);
  endfunction

  task automatic measure(output int span);
    bit ps;
    int t0;
    int seen;
    ps = carrier[OUT_W-1];
    seen = 0;
    t0 = 0;
    while (seen <= NPER) begin
      @(negedge clk);
      if (ps && !carrier[OUT_W-1]) begin
        if (seen == 0) t0 = cyc;
        seen++;
      end
      ps = carrier[OUT_W-1];
    end
    span = cyc - t0;
  endtask

  initial begin
    #(longint'(CLK_PERIOD) * 100000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int span, exp_span;
    logic [PH_W-1:0] l0, l1;
    rst_n = 1'b0;
    rx_tx_sel = 1'b1;
    tx_data = 1'b1;
    tmo_disable = 1'b0;
    tmo_short = 1'b0;
    tick(3);
    // R1: outputs during reset
    check({tx_active, drv_oe, pa_bias, pa_bias_n} == 4'b0001, "R1", {tx_active, drv_oe, pa_bias, pa_bias_n}, 1);
    rst_n = 1'b1;
    tick(8);
    check({tx_active, drv_oe, pa_bias, pa_bias_n} == 4'b0001, "R1", {tx_active, drv_oe, pa_bias, pa_bias_n}, 1);
    check(carrier == '0, "R1", carrier, 0);

    // R11: local oscillator advance in receive
    l0 = lo_phase;
    tick(100);
    l1 = lo_phase;
    check((l1 - l0) == PH_W'(100 * inc_of(LO_HZ)), "R11", l1 - l0, PH_W'(100 * inc_of(LO_HZ)));

    // R2 and R10: enter and leave transmit
    rx_tx_sel = 1'b0;
    push_exp(2, 1'b0, "R2");
    push_exp(3, 1'b1, "R2");
    drain();
    tick(20);
    l0 = lo_phase;
    tick(30);
    check(lo_phase == l0, "R11", lo_phase, l0);
    rx_tx_sel = 1'b1;
    push_exp(2, 1'b1, "R10");
    push_exp(3, 1'b0, "R10");
    drain();
    tick(2);
    check(carrier == '0, "R12", carrier, 0);

    // R3, R4, R5, R8: tones with the limit disabled
    tmo_disable = 1'b1;
    tx_data = 1'b0;
    tick(10);
    rx_tx_sel = 1'b0;
    tick(10);
    step_on = 1'b1;
    measure(span);
    exp_span = int'((longint'(NPER) * REF_HZ) / SPACE_HZ);
    check(span >= exp_span - 3 && span <= exp_span + 3, "R3", span, exp_span);
    tx_data = 1'b1;
    tick(10);
    measure(span);
    exp_span = int'((longint'(NPER) * REF_HZ) / MARK_HZ);
    check(span >= exp_span - 3 && span <= exp_span + 3, "R4", span, exp_span);
    for (int k = 0; k < 12; k++) begin
      tx_data = ~tx_data;
      tick(37 + k);
    end
    step_on = 1'b0;
    check(max_step <= (1 << (OUT_W - 1)) / 8, "R5", max_step, (1 << (OUT_W - 1)) / 8);
    check(tx_active == 1'b1, "R8", tx_active, 1);
    rx_tx_sel = 1'b1;
    tick(10);
    tmo_disable = 1'b0;
    tick(10);

    // R6: long limit
    rx_tx_sel = 1'b0;
    push_exp(3, 1'b1, "R6");
    push_exp(2 + T_LONG, 1'b1, "R6");
    push_exp(3 + T_LONG, 1'b0, "R6");
    drain();
    tick(20);
    check(carrier == '0, "R12", carrier, 0);

    // R7: too-short high pulse keeps the lockout
    rx_tx_sel = 1'b1;
    tick(MIN_HI - 1);
    rx_tx_sel = 1'b0;
    tick(40);
    check(tx_active == 1'b0, "R7", tx_active, 0);
    // R7: full-length high pulse re-arms transmit
    rx_tx_sel = 1'b1;
    tick(MIN_HI);
    rx_tx_sel = 1'b0;
    tick(10);
    check(tx_active == 1'b1, "R7", tx_active, 1);
    rx_tx_sel = 1'b1;
    tick(10);

    // R9: short limit
    tmo_short = 1'b1;
    tick(10);
    rx_tx_sel = 1'b0;
    push_exp(2 + T_SHORT, 1'b1, "R9");
    push_exp(3 + T_SHORT, 1'b0, "R9");
    drain();
    rx_tx_sel = 1'b1;
    tick(10);
    tmo_short = 1'b0;
    tick(5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule